// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Controller

This block is the device-side digital control for the serial port of a delta-sigma converter. It times each conversion from a selectable timebase, latches the parallel result from the converter core when the conversion ends, and then sleeps. A host pulls chip select low to wake it. While the conversion is still running, the data pin carries a busy/ready flag. Once the part is asleep, pulling chip select low starts the readout. The result is shifted out MSB first on a serial clock, which either the block or the host generates.

The clock direction is chosen from the level on the serial clock line. That level is sampled on the first clock after reset is released and again on every falling edge of chip select. If chip select returns high in the middle of a readout, the transfer stops at once and a new conversion begins. After a full word has been read out, a new conversion begins automatically. The conversion length is a parameterised number of timebase ticks. The count depends on the frequency-control level, or on whether an external oscillator is currently toggling.

All inputs are taken to be synchronous to `clk_i`. A high-impedance pin is modelled as a low output-enable.

Top module: `adc_readout_ctrl`

## Requirements
- R1: `sdo_oe_o` equals the inverse of `cs_n_i` in every cycle. While `cs_n_i` is high, `sdo_o` is not enabled.
- R2: The parallel result is captured only in the cycle a conversion completes. After that the block stays asleep for as long as `cs_n_i` is held high, and later changes on `result_i` do not alter the word that is read out.
- R3: With `cs_n_i` low outside the data phase, `sdo_o` is 1 while a conversion is running and 0 once a result is ready.
- R4: If `cs_n_i` is low while the block is asleep, the data phase starts on the next clock edge. The data phase can be entered only from sleep. The word is sent MSB first: bit 31 is on `sdo_o` at entry, and each later bit appears after a serial clock falling edge, so `sdo_o` is stable at every rising edge.
- R5: A rising edge of `cs_n_i` during the data phase ends the transfer on the next clock edge and starts a full-length conversion.
- R6: The level on `sck_i` is captured on the first clock after reset release and on each falling edge of `cs_n_i`. High selects internal clock mode and low selects external clock mode. `pullup_en_o` is 1 exactly when internal mode is selected.
- R7: In internal mode, `sck_oe_o` is high only in the data phase. During that phase `sck_o` starts high and runs exactly 32 periods of 2*SCK_HALF clocks, falling first, and then idles high.
- R8: In external mode, `sck_oe_o` stays low and the host's `sck_i` edges advance the data.
- R9: With the internal timebase, a conversion lasts TICKS_50*INT_DIV clocks when `fo_level_i` is 1 and TICKS_60*INT_DIV clocks when it is 0.
- R10: If an `ext_tick_i` pulse has been seen within the last EXT_TMO clocks, conversions count TICKS_EXT of those pulses and `fo_level_i` is ignored.
- R11: The 32nd rising serial clock edge ends the data phase, and a new conversion starts on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Level sensed on the serial clock line |
| fo_level_i | input | 1 | Frequency-control level, 1 = 50 Hz setting, 0 = 60 Hz setting |
| ext_tick_i | input | 1 | One-cycle pulse per external oscillator period |
| result_i | input | WORD_W | Parallel result from the converter core |
| sdo_o | output | 1 | Serial data / conversion status |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| sck_o | output | 1 | Generated serial clock |
| sck_oe_o | output | 1 | Output enable for sck_o |
| pullup_en_o | output | 1 | Weak pull-up request for the serial clock line |

## Verification
The assertions assume that `cs_n_i`, `sck_i` and `ext_tick_i` are already synchronous to `clk_i`. They also assume that in external mode each host clock level is held for at least one system clock, so that every edge is seen exactly once. The bench changes all inputs half a cycle away from the sampling edge and holds each host clock level for two cycles. It reaches the mode sample only after a chip-select fall or a reset, and when it does, the line is at the level it intends.

// File: rtl/adc_readout_pkg.sv
package adc_readout_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DATA  = 2'd2
  } rd_state_e;

  typedef enum logic [1:0] {
    TB_50  = 2'd0,
    TB_60  = 2'd1,
    TB_EXT = 2'd2
  } tb_sel_e;
endpackage

// File: rtl/adc_timebase.sv
module adc_timebase
  import adc_readout_pkg::*;
#(
  parameter int unsigned INT_DIV   = 8,
  parameter int unsigned EXT_TMO   = 64,
  parameter int unsigned TICKS_50  = 1200,
  parameter int unsigned TICKS_60  = 1000,
  parameter int unsigned TICKS_EXT = 1280,
  parameter int unsigned CNT_W     = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fo_level_i,
  input  logic             ext_tick_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] target_o,
  output tb_sel_e          sel_o
);
  localparam int unsigned WD_W  = $clog2(EXT_TMO + 1);
  localparam int unsigned PRE_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;

  logic [WD_W-1:0] wd_q;
  logic            ext_act;
  logic            pre_tick;

  // activity detector: external clock counts as present while pulses keep arriving
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wd_q <= '0;
    else if (ext_tick_i) wd_q <= WD_W'(EXT_TMO);
    else if (wd_q != '0) wd_q <= wd_q - 1'b1;
  end
  assign ext_act = (wd_q != '0);

  generate
    if (INT_DIV == 1) begin : g_nodiv
      assign pre_tick = 1'b1;
    end else begin : g_div
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          pre_q <= '0;
        else if (!run_i)                      pre_q <= '0;
        else if (pre_q == PRE_W'(INT_DIV - 1)) pre_q <= '0;
        else                                  pre_q <= pre_q + 1'b1;
      end
      assign pre_tick = (pre_q == PRE_W'(INT_DIV - 1));
    end
  endgenerate

  always_comb begin
    if (ext_act)         sel_o = TB_EXT;
    else if (fo_level_i) sel_o = TB_50;
    else                 sel_o = TB_60;
    unique case (sel_o)
      TB_EXT:  target_o = CNT_W'(TICKS_EXT);
      TB_50:   target_o = CNT_W'(TICKS_50);
      default: target_o = CNT_W'(TICKS_60);
    endcase
  end

  assign tick_o = run_i & (ext_act ? ext_tick_i : pre_tick);

  // R10
  ext_detect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_tick_i |=> (sel_o == TB_EXT));
endmodule

// File: rtl/adc_sck_engine.sv
module adc_sck_engine #(
  parameter int unsigned SCK_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic active_i,
  output logic int_mode_o,
  output logic cs_rise_o,
  output logic sck_o,
  output logic sck_oe_o,
  output logic fall_o,
  output logic rise_o
);
  localparam int unsigned DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic             init_q, cs_q, mode_q, sck_q, gen_q;
  logic [DIV_W-1:0] div_q;
  logic             cs_fall, toggle;

  assign cs_fall   = cs_q & ~cs_n_i;
  assign cs_rise_o = ~cs_q & cs_n_i;

  // mode captured once after reset release, then at each chip-select fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      cs_q   <= 1'b1;
      mode_q <= 1'b1;
      sck_q  <= 1'b1;
    end else begin
      init_q <= 1'b1;
      cs_q   <= cs_n_i;
      sck_q  <= sck_i;
      if (!init_q || cs_fall) mode_q <= sck_i;
    end
  end

  assign toggle = active_i & mode_q & (div_q == DIV_W'(SCK_HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      gen_q <= 1'b1;
    end else if (!(active_i && mode_q)) begin
      div_q <= '0;
      gen_q <= 1'b1;
    end else if (toggle) begin
      div_q <= '0;
      gen_q <= ~gen_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  always_comb begin
    if (mode_q) begin
      fall_o = toggle & gen_q;
      rise_o = toggle & ~gen_q;
    end else begin
      fall_o = active_i & sck_q & ~sck_i;
      rise_o = active_i & ~sck_q & sck_i;
    end
  end

  assign int_mode_o = mode_q;
  assign sck_o      = gen_q;
  assign sck_oe_o   = active_i & mode_q;

  // R6
  mode_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_i) |=> (int_mode_o == $past(sck_i)));
  // R7
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> sck_o);
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              msb_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (load_i)  word_q <= data_i;
    else if (shift_i) word_q <= {word_q[WORD_W-2:0], 1'b0};
  end

  assign msb_o = word_q[WORD_W-1];

  // R2
  load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (msb_o == $past(data_i[WORD_W-1])));
  // R4
  hold_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(msb_o));
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_readout_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned INT_DIV   = 8,
  parameter int unsigned EXT_TMO   = 64,
  parameter int unsigned TICKS_50  = 1200,
  parameter int unsigned TICKS_60  = 1000,
  parameter int unsigned TICKS_EXT = 1280,
  parameter int unsigned SCK_HALF  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              fo_level_i,
  input  logic              ext_tick_i,
  input  logic [WORD_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              pullup_en_o
);
  localparam int unsigned MAX_T = (TICKS_50 > TICKS_60)
                                ? ((TICKS_50 > TICKS_EXT) ? TICKS_50 : TICKS_EXT)
                                : ((TICKS_60 > TICKS_EXT) ? TICKS_60 : TICKS_EXT);
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);
  localparam int unsigned BIT_W = $clog2(WORD_W);

  rd_state_e        state_q;
  logic [CNT_W-1:0] conv_cnt_q, target;
  logic [BIT_W-1:0] bit_cnt_q;
  logic             tick, conv_last, load, shift, msb;
  logic             int_mode, cs_rise, fall_ev, rise_ev;
  tb_sel_e          tb_sel;

  adc_timebase #(
    .INT_DIV(INT_DIV), .EXT_TMO(EXT_TMO), .TICKS_50(TICKS_50),
    .TICKS_60(TICKS_60), .TICKS_EXT(TICKS_EXT), .CNT_W(CNT_W)
  ) u_tb (
    .clk_i, .rst_ni,
    .run_i      (state_q == ST_CONV),
    .fo_level_i,
    .ext_tick_i,
    .tick_o     (tick),
    .target_o   (target),
    .sel_o      (tb_sel)
  );

  adc_sck_engine #(.SCK_HALF(SCK_HALF)) u_sck (
    .clk_i, .rst_ni, .cs_n_i, .sck_i,
    .active_i   (state_q == ST_DATA),
    .int_mode_o (int_mode),
    .cs_rise_o  (cs_rise),
    .sck_o,
    .sck_oe_o,
    .fall_o     (fall_ev),
    .rise_o     (rise_ev)
  );

  adc_shift_out #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i  (load),
    .shift_i (shift),
    .data_i  (result_i),
    .msb_o   (msb)
  );

  assign conv_last = ({1'b0, conv_cnt_q} + 1'b1) >= {1'b0, target};
  assign load      = (state_q == ST_CONV) & tick & conv_last;
  // first falling edge keeps the MSB that was presented at entry
  assign shift     = (state_q == ST_DATA) & fall_ev & (bit_cnt_q != '0) & ~cs_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_CONV;
      conv_cnt_q <= '0;
      bit_cnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_CONV: if (tick) begin
          if (conv_last) begin
            state_q    <= ST_SLEEP;
            conv_cnt_q <= '0;
          end else begin
            conv_cnt_q <= conv_cnt_q + 1'b1;
          end
        end
        ST_SLEEP: if (!cs_n_i) begin
          state_q   <= ST_DATA;
          bit_cnt_q <= '0;
        end
        ST_DATA: begin
          if (cs_rise) begin
            state_q <= ST_CONV;
          end else if (rise_ev) begin
            if (bit_cnt_q == BIT_W'(WORD_W - 1)) state_q <= ST_CONV;
            else bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_CONV;
      endcase
    end
  end

  always_comb begin
    if (cs_n_i)                  sdo_o = 1'b0;
    else if (state_q == ST_DATA) sdo_o = msb;
    else                         sdo_o = (state_q == ST_CONV);
  end

  assign sdo_oe_o    = ~cs_n_i;
  assign pullup_en_o = int_mode;

  // R5
  abort_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && cs_n_i) |=> (state_q == ST_CONV));
  // R2
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && cs_n_i) |=> (state_q == ST_SLEEP));
  // R4
  data_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV) |=> (state_q != ST_DATA));
  // R7
  ext_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pullup_en_o |-> !sck_oe_o);
endmodule

// File: tb/adc_readout_ctrl_test.sv
module adc_readout_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int INT_DIV = 2, T50 = 6, T60 = 5, TEXT = 7, SCK_HALF = 2, EXT_P = 3;

  logic clk = 0, rst_n = 0, cs_n = 1, fo = 1, ext_tick = 0;
  logic host_drive = 0, host_sck = 1, ext_en = 0;
  logic [31:0] result = '0;
  logic sdo, sdo_oe, sck_o, sck_oe, pullup_en, sck_line;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sck_line = sck_oe ? sck_o : (host_drive ? host_sck : pullup_en);

  adc_readout_ctrl #(
    .WORD_W(32), .INT_DIV(INT_DIV), .EXT_TMO(16), .TICKS_50(T50),
    .TICKS_60(T60), .TICKS_EXT(TEXT), .SCK_HALF(SCK_HALF)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sck_i(sck_line),
    .fo_level_i(fo), .ext_tick_i(ext_tick), .result_i(result),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sck_o(sck_o), .sck_oe_o(sck_oe),
    .pullup_en_o(pullup_en)
  );

  initial begin : ext_gen
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph == EXT_P - 1) ? 0 : ph + 1;
      ext_tick = ext_en && (ph == 0);
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start_fresh(input logic [31:0] pat);
    @(negedge clk);
    result = pat;
    cs_n = 1;
    #1 check(sdo_oe == 0, "R1 oe with cs high", sdo_oe, 0);
    repeat (60) @(negedge clk);
    result = ~pat;  // later changes must not reach the latched word
  endtask

  task automatic count_hi(output int n);
    n = 0;
    while (sdo === 1'b1 && n < 5000) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic read_int(input logic [31:0] exp);
    logic [31:0] got = '0;
    int nb = 0, nf = 0;
    bit saw_oe = 0;
    logic prev_sck, prev_sdo;
    host_drive = 1; host_sck = 1;
    @(negedge clk); cs_n = 0; #1;
    check(sdo == 0 && sdo_oe == 1, "R3 ready status", sdo, 0);
    prev_sck = sck_line; prev_sdo = sdo;
    for (int c = 0; c < 2000 && nb < 32; c++) begin
      @(negedge clk); #1;
      if (sck_oe) saw_oe = 1;
      if (!sck_line && prev_sck) nf++;
      if (sck_line && !prev_sck) begin got = {got[30:0], prev_sdo}; nb++; end
      prev_sck = sck_line; prev_sdo = sdo;
    end
    check(got == exp, "R4 internal word", got, exp);
    check(nf == 32, "R7 sck periods", nf, 32);
    check(saw_oe && pullup_en, "R6 internal mode drive", {saw_oe, pullup_en}, 3);
    check(!sck_oe && sck_line, "R7 sck idle high", {sck_oe, sck_line}, 1);
  endtask

  task automatic read_ext(input logic [31:0] exp, input int nbits);
    logic [31:0] got = '0;
    bit saw_oe = 0;
    host_drive = 1; host_sck = 0;
    @(negedge clk); cs_n = 0; #1;
    check(sdo == 0, "R3 ready status ext", sdo, 0);
    for (int b = 0; b < nbits; b++) begin
      repeat (2) @(negedge clk); #1;
      got = {got[30:0], sdo};
      if (sck_oe) saw_oe = 1;
      host_sck = 1;
      if (!(nbits == 32 && b == 31)) begin
        repeat (2) @(negedge clk); #1;
        if (sck_oe) saw_oe = 1;
        host_sck = 0;
      end
    end
    check(got == (exp >> (32 - nbits)), "R8 external word", got, exp >> (32 - nbits));
    check(!saw_oe && !pullup_en, "R6 external mode", {saw_oe, pullup_en}, 0);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    int n;
    logic [31:0] pat;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    check(sdo_oe == 0 && sck_oe == 0, "R1 reset outputs", {sdo_oe, sck_oe}, 0);
    @(negedge clk); #1;
    check(pullup_en == 1, "R6 reset-release sample high", pullup_en, 1);
    cs_n = 0; #1;
    check(sdo == 1 && sdo_oe == 1, "R3 busy status", sdo, 1);
    @(negedge clk); cs_n = 1; #1;
    check(sdo_oe == 0, "R1 cs high", sdo_oe, 0);

    // sweep patterns over both clock modes and both fo settings
    for (int i = 0; i < 4; i++) begin
      pat = 32'h9E37_79B9 * (i + 1) ^ (32'h8000_0001 << i);
      fo = i[0];
      start_fresh(pat);
      repeat (40) @(negedge clk);  // R2 long sleep with cs high
      read_int(pat);
      count_hi(n);
      check(n == (fo ? T50 : T60) * INT_DIV, "R9 R11 conv length internal", n, (fo ? T50 : T60) * INT_DIV);
      start_fresh(~pat);
      read_ext(~pat, 32);
      @(negedge clk); #1;
      count_hi(n);
      check(n == (fo ? T50 : T60) * INT_DIV, "R11 restart after ext read", n, (fo ? T50 : T60) * INT_DIV);
    end

    // R5 abort in mid transfer
    fo = 1;
    pat = 32'hC3A5_5A3C;
    start_fresh(pat);
    read_ext(pat, 8);
    @(negedge clk); cs_n = 1; #1;
    check(sdo_oe == 0, "R5 R1 oe drops on abort", sdo_oe, 0);
    @(negedge clk); cs_n = 0; #1;
    check(sdo == 1, "R5 new conversion busy", sdo, 1);
    count_hi(n);
    check(n == T50 * INT_DIV, "R5 full length after abort", n, T50 * INT_DIV);
    pat = 32'h0F0F_1234;
    start_fresh(pat);
    read_int(pat);

    // R10 external timebase, fo ignored
    ext_en = 1;
    for (int f = 0; f < 2; f++) begin
      fo = f[0];
      start_fresh(32'h5555_AAAA + f);
      read_int(32'h5555_AAAA + f);
      count_hi(n);
      check(n >= (TEXT - 1) * EXT_P + 1 && n <= TEXT * EXT_P, "R10 ext conv length", n, TEXT * EXT_P);
    end
    ext_en = 0;
    repeat (40) @(negedge clk);

    // R6 reset release with line low selects external
    rst_n = 0; host_drive = 1; host_sck = 0; cs_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk); #1;
    check(pullup_en == 0, "R6 reset-release sample low", pullup_en, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule